// File: doc/BRIEF.md
# GPIO Bank with Latched Interrupt Detection

This block is one bank of general-purpose pins, up to 32 wide, reached through a small word-addressed register port. For each pin it keeps a drive value, a drive-enable bit and a synchronized copy of the pin level. Software turns a pin into an output by setting its drive-enable bit. It reads the pin back through the input register whichever way the pin points.

Each pin also feeds an interrupt detector. The detector works on either edges or levels, and the active sense is set per pin. Every detected event sets a sticky pending bit, and software removes it by writing a one to the clear register. The pending bits that are also enabled are ORed onto a single interrupt output. Level events latch just as edges do. A pin that must interrupt on both edges is handled in edge mode: software inverts the pin's sense bit after each event. Moving the sense to the level the pin already holds counts as an event in its own right.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, pin_out and pin_oe are all zero and irq is low.
- R2: Byte offsets 0x00 (drive value), 0x10 (drive enable), 0x60 (mode, 1 = edge, 0 = level), 0x70 (sense, 1 = rising/high, 0 = falling/low) and 0x80 (interrupt enable) read back what was written. pin_out and pin_oe follow their registers from the cycle after the write. The clear offset 0x90 and unmapped offsets read zero.
- R3: Offset 0x34 returns pin_in after a two-stage synchronizer, so a pin change is readable two clock edges later.
- R4: In edge mode a pin transition toward its sense sets the pin's pending bit (status, offset 0xA0). A transition away from the sense sets nothing.
- R5: In level mode the pending bit is set while the pin sits at its active level. It stays set after the level goes away, until it is cleared.
- R6: Writing to offset 0x90 clears exactly the pending bits written as one. Bits written as zero are unchanged.
- R7: An event that arrives on the same edge as a clear of its bit leaves the bit set.
- R8: In edge mode, changing the sense bit to the level the pin currently holds sets the pending bit. Changing it to the other level sets nothing.
- R9: Pending bits latch whatever the enable bits hold. irq is high exactly when some pin is both pending and enabled.
- R10: For the first three clock edges after reset release no event is detected, so reset-state sample values never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | DATA_W | Write data, one bit per pin |
| bus_rdata | output | DATA_W | Read data for bus_addr, zero-extended |
| pin_in | input | NUM_PINS | Pin levels, asynchronous to clk |
| pin_out | output | NUM_PINS | Drive value per pin |
| pin_oe | output | NUM_PINS | Drive enable per pin |
| irq | output | 1 | OR of pending and enabled pins |

## Verification
The assertions assume that the bus strobe and address are known on every clock edge. They also assume that pin_in holds each level long enough to pass the synchronizer, so that every transition reaches the detector as a separate sample. The stimulus changes pins and bus signals only on the falling clock edge. It holds each pin level for at least four cycles before the next change or check. Edge, level, sense-flip and clear-collision cases are each placed on a pin whose history the bench controls exactly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // byte offsets of the register port
  localparam int OFS_OUT  = 'h00;
  localparam int OFS_OE   = 'h10;
  localparam int OFS_IN   = 'h34;
  localparam int OFS_MODE = 'h60;
  localparam int OFS_POL  = 'h70;
  localparam int OFS_IEN  = 'h80;
  localparam int OFS_CLR  = 'h90;
  localparam int OFS_STAT = 'hA0;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_OUT, SEL_OE, SEL_IN, SEL_MODE,
    SEL_POL, SEL_IEN, SEL_CLR, SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q, stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic [WIDTH-1:0] smp,
  input  logic [WIDTH-1:0] mode,
  input  logic [WIDTH-1:0] pol,
  output logic [WIDTH-1:0] evt
);
  // act: pin sits at its selected sense; an edge is act rising
  logic [WIDTH-1:0] act, act_q;

  assign act = ~(smp ^ pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act;
  end

  always_comb begin
    if (ready) evt = (mode & act & ~act_q) | (~mode & act);
    else       evt = '0;
  end

  assert_warmup_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (evt == '0));

  assert_edge_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready) |-> ((evt & mode & $past(mode) & ~($past(smp) ^ smp)
                       & ~($past(pol) ^ pol)) == '0));
endmodule

// File: rtl/gpio_pending.sv
module gpio_pending #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] stat
);
  logic [WIDTH-1:0] stat_q, stat_d;

  // a new event overrides a clear on the same edge
  assign stat_d = (stat_q & ~clr) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;

  assert_hold_without_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(clr)) == '0));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt) & ~stat_q) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] wpins, clr_vec, smp, evt, stat;
  logic [NUM_PINS-1:0] out_q, out_d, oe_q, oe_d, mode_q, mode_d;
  logic [NUM_PINS-1:0] pol_q, pol_d, ien_q, ien_d, rd_pins;
  logic                en_out, en_oe, en_mode, en_pol, en_ien;
  logic [CW-1:0]       warm_q, warm_d;
  logic                ready;

  // address decode
  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_OUT):  sel = SEL_OUT;
      ADDR_W'(OFS_OE):   sel = SEL_OE;
      ADDR_W'(OFS_IN):   sel = SEL_IN;
      ADDR_W'(OFS_MODE): sel = SEL_MODE;
      ADDR_W'(OFS_POL):  sel = SEL_POL;
      ADDR_W'(OFS_IEN):  sel = SEL_IEN;
      ADDR_W'(OFS_CLR):  sel = SEL_CLR;
      ADDR_W'(OFS_STAT): sel = SEL_STAT;
      default:           sel = SEL_NONE;
    endcase
  end

  assign wpins   = bus_wdata[NUM_PINS-1:0];
  assign en_out  = bus_we && (sel == SEL_OUT);
  assign en_oe   = bus_we && (sel == SEL_OE);
  assign en_mode = bus_we && (sel == SEL_MODE);
  assign en_pol  = bus_we && (sel == SEL_POL);
  assign en_ien  = bus_we && (sel == SEL_IEN);
  assign clr_vec = (bus_we && (sel == SEL_CLR)) ? wpins : '0;

  // next state of the control registers
  always_comb begin
    out_d  = en_out  ? wpins : out_q;
    oe_d   = en_oe   ? wpins : oe_q;
    mode_d = en_mode ? wpins : mode_q;
    pol_d  = en_pol  ? wpins : pol_q;
    ien_d  = en_ien  ? wpins : ien_q;
    warm_d = ready   ? warm_q : warm_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      oe_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      warm_q <= '0;
    end else begin
      out_q  <= out_d;
      oe_q   <= oe_d;
      mode_q <= mode_d;
      pol_q  <= pol_d;
      ien_q  <= ien_d;
      warm_q <= warm_d;
    end
  end

  assign ready = (warm_q == CW'(WARM));

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp));

  gpio_irq_detect #(.WIDTH(NUM_PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .ready(ready), .smp(smp),
    .mode(mode_q), .pol(pol_q), .evt(evt));

  gpio_pending #(.WIDTH(NUM_PINS)) u_pending (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr_vec), .stat(stat));

  // read-back
  always_comb begin
    case (sel)
      SEL_OUT:  rd_pins = out_q;
      SEL_OE:   rd_pins = oe_q;
      SEL_IN:   rd_pins = smp;
      SEL_MODE: rd_pins = mode_q;
      SEL_POL:  rd_pins = pol_q;
      SEL_IEN:  rd_pins = ien_q;
      SEL_STAT: rd_pins = stat;
      default:  rd_pins = '0;
    endcase
  end

  assign bus_rdata = DATA_W'(rd_pins);
  assign pin_out   = out_q;
  assign pin_oe    = oe_q;
  assign irq       = |(stat & ien_q);

  assert_out_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_out |=> (pin_out == $past(wpins)));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  localparam logic [7:0] A_OUT = 8'h00, A_OE = 8'h10, A_IN = 8'h34, A_MODE = 8'h60;
  localparam logic [7:0] A_POL = 8'h70, A_IEN = 8'h80, A_CLR = 8'h90, A_STAT = 8'hA0;
  localparam int K_REG = 0, K_OUT = 1, K_OE = 2, K_IRQ = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out, pin_oe;
  logic        irq;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  gpio_irq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // monitor: pops expected items and compares away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_OUT:   act = pin_out;
          K_OE:    act = pin_oe;
          K_IRQ:   act = {31'd0, irq};
          default: act = bus_rdata;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk_now(input int k, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.kind = k; it.exp = e; it.tag = tag;
    q.push_back(it);
    #4;
  endtask

  task automatic chk(input int k, input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    chk_now(k, a, e, tag);
  endtask

  task automatic setpin(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = 8'h00; bus_we = 1'b0; bus_wdata = '0; pin_in = '1;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    chk(K_OUT, A_OUT, 32'h0, "R1 pin_out");
    chk(K_OE, A_OUT, 32'h0, "R1 pin_oe");
    chk(K_IRQ, A_OUT, 32'h0, "R1 irq");
    chk(K_REG, A_MODE, 32'h0, "R1 mode");
    chk(K_REG, A_POL, 32'h0, "R1 pol");
    chk(K_REG, A_IEN, 32'h0, "R1 ien");
    idle(4);
    chk(K_REG, A_STAT, 32'h0, "R1 status");
    // R2 register port
    wr(A_OUT, 32'hA5A5_5A5A);
    chk_now(K_OUT, A_OUT, 32'hA5A5_5A5A, "R2 pin_out");
    chk(K_REG, A_OUT, 32'hA5A5_5A5A, "R2 out readback");
    wr(A_OE, 32'hFFFF_0000);
    chk_now(K_OE, A_OE, 32'hFFFF_0000, "R2 pin_oe");
    chk(K_REG, A_OE, 32'hFFFF_0000, "R2 oe readback");
    wr(A_MODE, 32'hFFFF_FFFF);
    chk(K_REG, A_MODE, 32'hFFFF_FFFF, "R2 mode readback");
    wr(A_POL, 32'h1234_5678);
    chk(K_REG, A_POL, 32'h1234_5678, "R2 pol readback");
    wr(A_IEN, 32'h0F0F_0F0F);
    chk(K_REG, A_IEN, 32'h0F0F_0F0F, "R2 ien readback");
    chk(K_REG, A_CLR, 32'h0, "R2 clear reads zero");
    chk(K_REG, 8'h04, 32'h0, "R2 unmapped reads zero");
    wr(A_POL, 32'hFFFF_FFFF);
    idle(3);
    wr(A_CLR, 32'hFFFF_FFFF);
    idle(3);
    chk(K_REG, A_STAT, 32'h0, "R6 full clear");
    // R3 input sample, R4 falling away from sense
    setpin(32'hFFFF_FF0F);
    idle(3);
    chk(K_REG, A_IN, 32'hFFFF_FF0F, "R3 input read");
    chk(K_REG, A_STAT, 32'h0, "R4 opposite edge ignored");
    // R4 rising edges, R9 mask
    setpin(32'hFFFF_FFFF);
    idle(3);
    chk(K_REG, A_STAT, 32'h0000_00F0, "R4 rising edges");
    chk(K_IRQ, A_STAT, 32'h0, "R9 pending but masked");
    wr(A_IEN, 32'hFFFF_FFFF);
    chk_now(K_IRQ, A_STAT, 32'h1, "R9 irq after enable");
    // R6 partial clear
    wr(A_CLR, 32'h0000_0030);
    chk_now(K_REG, A_STAT, 32'h0000_00C0, "R6 partial clear");
    wr(A_CLR, 32'h0);
    chk_now(K_REG, A_STAT, 32'h0000_00C0, "R6 zero write no effect");
    wr(A_CLR, 32'h0000_00C0);
    chk_now(K_IRQ, A_STAT, 32'h0, "R9 irq drops");
    // R4 falling sense
    wr(A_POL, 32'hFFFF_FFFE);
    setpin(32'hFFFF_FFFE);
    idle(3);
    chk(K_REG, A_STAT, 32'h1, "R4 falling edge");
    wr(A_CLR, 32'h1);
    // R8 sense flip
    wr(A_POL, 32'hFFFF_FFFF);
    idle(2);
    chk(K_REG, A_STAT, 32'h0, "R8 flip to inactive level");
    wr(A_POL, 32'hFFFF_FFFE);
    idle(1);
    chk(K_REG, A_STAT, 32'h1, "R8 flip to active level");
    wr(A_CLR, 32'h1);
    setpin(32'hFFFF_FFFF);
    idle(4);
    chk(K_REG, A_STAT, 32'h0, "R4 rising with falling sense ignored");
    // R5 level mode on pin 1
    setpin(32'hFFFF_FFFD);
    idle(4);
    wr(A_MODE, 32'hFFFF_FFFD);
    idle(2);
    chk(K_REG, A_STAT, 32'h0, "R5 inactive level");
    setpin(32'hFFFF_FFFF);
    idle(4);
    chk(K_REG, A_STAT, 32'h2, "R5 active level");
    setpin(32'hFFFF_FFFD);
    idle(4);
    chk(K_REG, A_STAT, 32'h2, "R5 latched after level gone");
    wr(A_CLR, 32'h2);
    chk_now(K_REG, A_STAT, 32'h0, "R6 level clear");
    setpin(32'hFFFF_FFFF);
    idle(4);
    wr(A_CLR, 32'h2);
    chk_now(K_REG, A_STAT, 32'h2, "R7 event beats clear");
    setpin(32'hFFFF_FFFD);
    idle(4);
    wr(A_CLR, 32'h2);
    chk_now(K_REG, A_STAT, 32'h0, "R7 clear after level gone");
    // R10 warm-up after reset with all pins low
    @(negedge clk);
    rst_n = 1'b0; pin_in = '0;
    idle(3);
    rst_n = 1'b1;
    chk(K_REG, A_STAT, 32'h0, "R10 no event during warm-up");
    idle(4);
    chk(K_REG, A_STAT, 32'hFFFF_FFFF, "R5 default active-low level");
    chk(K_IRQ, A_STAT, 32'h0, "R9 latched while disabled");
    chk(K_REG, A_MODE, 32'h0, "R1 mode after second reset");
    idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule